// File: doc/BRIEF.md
# Card Supply Fault Monitor

This block watches the health indications around a smart-card slot and turns them into two clean outputs: a one-cycle request that tells the power sequencer to shut the card down, and an active-low alarm level for the host. Its inputs are comparator flags for the logic supply falling under each of two thresholds, a threshold-select strap, an overcurrent flag from the card supply regulator, a thermal flag, a card-present contact and the host's activation command. The flags come from analog circuits and are asynchronous, so every one of them passes through a synchroniser first.

The threshold select decides how an undervoltage is treated. With the strap high, the lower threshold is used and a crossing acts at once. With the strap low, the higher threshold is used, and its comparator must stay asserted for a programmable number of internal oscillator ticks (50 ticks, about 20 µs at 2.5 MHz) before it counts as a fault. Any return to good supply restarts that count. Overcurrent, over-temperature and card removal act at once. Once the alarm has dropped, it stays low after the fault has gone, and it is released only by a rising edge of the host command.

Top module: `supply_fault_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `alarm_n` is 1 and `deact_req` is 0.
- R2: Every input passes through a synchroniser of `SYNC_STAGES` (default 2) flip-flops. An immediate fault driven just before clock edge k makes `deact_req` high for the cycle that follows edge k+2.
- R3: With `sel_low_thr` = 1, `vdd_below_lo` = 1 is an immediate fault, and `vdd_below_hi` alone has no effect on either output.
- R4: With `sel_low_thr` = 0, `vdd_below_hi` becomes a fault only after it has been sampled high on `FILT_TICKS` cycles in which `osc_tick` = 1. In this mode `vdd_below_lo` alone has no effect.
- R5: Each time `vdd_below_hi` is sampled low, the tick count restarts from zero. Dips shorter than `FILT_TICKS` ticks never produce a fault, however many of them occur.
- R6: `vcc_overcur` = 1, `over_temp` = 1 and `card_in` = 0 are each an immediate fault. Each one pulses `deact_req` and drives `alarm_n` to 0.
- R7: `deact_req` is high for exactly one cycle when the combined fault condition turns on. A fault that persists, or a second fault that arrives while one is already present, gives no further pulse.
- R8: After a fault, `alarm_n` stays 0 once the fault has cleared. It returns to 1 only in response to a 0-to-1 transition on `host_cmd`.
- R9: A rising edge of `host_cmd` while any fault is still present leaves `alarm_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle enable at the internal oscillator rate, used by the undervoltage filter |
| vdd_below_lo | input | 1 | Logic supply is under the lower threshold (asynchronous) |
| vdd_below_hi | input | 1 | Logic supply is under the higher threshold (asynchronous) |
| sel_low_thr | input | 1 | 1 selects the lower threshold, which acts at once; 0 selects the higher threshold, which is filtered |
| vcc_overcur | input | 1 | Card supply current is above the short-circuit limit |
| over_temp | input | 1 | Die temperature is too high |
| card_in | input | 1 | 1 while a card is present |
| host_cmd | input | 1 | Host activation command; a rising edge releases the alarm |
| deact_req | output | 1 | One-cycle request to the sequencer to deactivate the card |
| alarm_n | output | 1 | Latched fault alarm, active low |

## Verification
Each immediate source is driven alone so that its pulse cycle and alarm latch can be observed separately. The two undervoltage comparators are then crossed with both settings of the threshold select, which shows that each mode listens only to its own comparator. In filtered mode, a train of short dips is followed by one sustained violation: the dips show that the count restarts, and the sustained violation shows that the fault fires inside the expected window. Overlapping faults, and host edges that arrive while a fault is still present, show apart the pulse-on-onset rule and the rule that a fault's set overrides a host release.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;

  typedef struct packed {
    logic below_lo;
    logic below_hi;
    logic sel_lo;
    logic overcur;
    logic hot;
    logic card_in;
    logic host_cmd;
  } fm_in_t;

  localparam int FM_IN_W = $bits(fm_in_t);

  // Safe values held by the synchronisers during reset: no fault, no host edge.
  localparam fm_in_t FM_IDLE = '{
    below_lo: 1'b0,
    below_hi: 1'b0,
    sel_lo:   1'b1,
    overcur:  1'b0,
    hot:      1'b0,
    card_in:  1'b1,
    host_cmd: 1'b1
  };

endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
module fm_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/fm_uv_filter.sv
`timescale 1ns/1ps
module fm_uv_filter #(
  parameter int LIMIT = 50,
  parameter int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             low,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);

  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !low)                  cnt_q <= '0;
    else if (tick && cnt_q != LIM_V)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign done = (cnt_q == LIM_V);

endmodule

// File: rtl/fm_alarm.sv
`timescale 1ns/1ps
module fm_alarm (
  input  logic clk,
  input  logic rst,
  input  logic fault_now,
  input  logic host_rise,
  output logic deact_req,
  output logic alarm_n
);

  logic fault_q;
  logic req_q;
  logic alarm_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q   <= 1'b0;
      req_q     <= 1'b0;
      alarm_n_q <= 1'b1;
    end else begin
      fault_q <= fault_now;
      req_q   <= fault_now & ~fault_q;
      if (fault_now)      alarm_n_q <= 1'b0;
      else if (host_rise) alarm_n_q <= 1'b1;
    end
  end

  assign deact_req = req_q;
  assign alarm_n   = alarm_n_q;

endmodule

// File: rtl/supply_fault_monitor.sv
`timescale 1ns/1ps
module supply_fault_monitor
  import fm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TICKS  = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_tick,
  input  logic vdd_below_lo,
  input  logic vdd_below_hi,
  input  logic sel_low_thr,
  input  logic vcc_overcur,
  input  logic over_temp,
  input  logic card_in,
  input  logic host_cmd,
  output logic deact_req,
  output logic alarm_n
);

  localparam int CNT_W = $clog2(FILT_TICKS + 1);

  fm_in_t raw_in;
  fm_in_t syn;
  logic   host_q;
  logic   host_rise;
  logic [CNT_W-1:0] uv_cnt;
  logic   uv_slow;
  logic   uv_fault;
  logic   fault_now;

  assign raw_in = '{
    below_lo: vdd_below_lo,
    below_hi: vdd_below_hi,
    sel_lo:   sel_low_thr,
    overcur:  vcc_overcur,
    hot:      over_temp,
    card_in:  card_in,
    host_cmd: host_cmd
  };

  fm_sync #(
    .W(FM_IN_W),
    .STAGES(SYNC_STAGES),
    .RST_VAL(FM_IDLE)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d(raw_in),
    .q(syn)
  );

  always_ff @(posedge clk) begin
    if (rst) host_q <= 1'b1;
    else     host_q <= syn.host_cmd;
  end

  assign host_rise = syn.host_cmd & ~host_q;

  fm_uv_filter #(
    .LIMIT(FILT_TICKS),
    .CNT_W(CNT_W)
  ) u_filt (
    .clk(clk),
    .rst(rst),
    .tick(osc_tick),
    .low(syn.below_hi),
    .cnt(uv_cnt),
    .done(uv_slow)
  );

  assign uv_fault  = syn.sel_lo ? syn.below_lo : uv_slow;
  assign fault_now = uv_fault | syn.overcur | syn.hot | ~syn.card_in;

  fm_alarm u_alarm (
    .clk(clk),
    .rst(rst),
    .fault_now(fault_now),
    .host_rise(host_rise),
    .deact_req(deact_req),
    .alarm_n(alarm_n)
  );

endmodule

// File: rtl/sfm_checker.sv
`timescale 1ns/1ps
module sfm_checker #(
  parameter int FILT_TICKS = 50,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             deact_req,
  input logic             alarm_n,
  input logic             host_rise,
  input logic             fault_now,
  input logic             sel_s,
  input logic             lo_s,
  input logic [CNT_W-1:0] uv_cnt
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (alarm_n && !deact_req));

  p_fast_uv_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_s && lo_s) |=> !alarm_n);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    uv_cnt <= CNT_W'(FILT_TICKS));

  p_alarm_on_req_r6: assert property (@(posedge clk) disable iff (rst)
    deact_req |-> !alarm_n);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    deact_req |=> !deact_req);

  p_release_by_host_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_n) |-> $past(host_rise));

  p_release_clean_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_n) |-> $past(!fault_now));

endmodule

bind supply_fault_monitor sfm_checker #(
  .FILT_TICKS(FILT_TICKS),
  .CNT_W(CNT_W)
) chk_i (
  .clk(clk),
  .rst(rst),
  .deact_req(deact_req),
  .alarm_n(alarm_n),
  .host_rise(host_rise),
  .fault_now(fault_now),
  .sel_s(syn.sel_lo),
  .lo_s(syn.below_lo),
  .uv_cnt(uv_cnt)
);

// File: tb/supply_fault_monitor_tb_top.sv
`timescale 1ns/1ps
module supply_fault_monitor_tb_top;

  localparam int FILT = 50;
  localparam int TP   = 4;   // tick period in clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_tick = 1'b0;
  logic vdd_below_lo = 1'b0, vdd_below_hi = 1'b0, sel_low_thr = 1'b1;
  logic vcc_overcur = 1'b0, over_temp = 1'b0, card_in = 1'b1, host_cmd = 1'b1;
  logic deact_req, alarm_n;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    lo;
    int    hi;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) osc_tick <= (cyc % TP == TP - 1);

  supply_fault_monitor #(.SYNC_STAGES(2), .FILT_TICKS(FILT)) dut_i (
    .clk(clk), .rst(rst), .osc_tick(osc_tick),
    .vdd_below_lo(vdd_below_lo), .vdd_below_hi(vdd_below_hi),
    .sel_low_thr(sel_low_thr), .vcc_overcur(vcc_overcur),
    .over_temp(over_temp), .card_in(card_in), .host_cmd(host_cmd),
    .deact_req(deact_req), .alarm_n(alarm_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic want_pulse(input int lo, input int hi, input string tag);
    exp_t e;
    e.lo = lo; e.hi = hi; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic release_alarm();
    host_cmd = 1'b0;
    idle(4);
    host_cmd = 1'b1;
    idle(6);
  endtask

  // Monitor: every observed pulse must match the head of the scoreboard.
  always @(negedge clk) begin
    if (!rst && deact_req) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected deact_req", cyc, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cyc >= e.lo && cyc <= e.hi, e.tag, cyc, e.lo);
      end
    end
  end

  initial begin
    idle(5);
    chk(alarm_n == 1'b1 && deact_req == 1'b0, "R1 idle in reset", alarm_n, 1);
    rst = 1'b0;
    idle(1);
    chk(alarm_n == 1'b1 && deact_req == 1'b0, "R1 idle after reset", alarm_n, 1);
    idle(5);

    // R6 / R2: overcurrent, exact latency
    vcc_overcur = 1'b1; want_pulse(cyc + 3, cyc + 3, "R2 R6 overcurrent pulse");
    idle(10);
    chk(alarm_n == 1'b0, "R6 alarm on overcurrent", alarm_n, 0);
    vcc_overcur = 1'b0; idle(10);
    chk(alarm_n == 1'b0, "R8 alarm held after clear", alarm_n, 0);
    release_alarm();
    chk(alarm_n == 1'b1, "R8 alarm released by host edge", alarm_n, 1);

    // R6: over-temperature
    over_temp = 1'b1; want_pulse(cyc + 3, cyc + 3, "R6 thermal pulse");
    idle(10);
    chk(alarm_n == 1'b0, "R6 alarm on thermal", alarm_n, 0);
    over_temp = 1'b0; idle(5); release_alarm();

    // R6: card removal
    card_in = 1'b0; want_pulse(cyc + 3, cyc + 3, "R6 card removal pulse");
    idle(10);
    chk(alarm_n == 1'b0, "R6 alarm on card removal", alarm_n, 0);
    card_in = 1'b1; idle(5); release_alarm();

    // R3: lower threshold mode
    sel_low_thr = 1'b1; vdd_below_hi = 1'b1; idle(300);
    chk(alarm_n == 1'b1, "R3 high comparator ignored", alarm_n, 1);
    vdd_below_hi = 1'b0; idle(5);
    vdd_below_lo = 1'b1; want_pulse(cyc + 3, cyc + 3, "R3 immediate low-threshold pulse");
    idle(30);  // R7: held fault, still a single pulse
    chk(alarm_n == 1'b0, "R3 alarm on low threshold", alarm_n, 0);
    vdd_below_lo = 1'b0; idle(5); release_alarm();

    // R9: host edge while fault present
    vcc_overcur = 1'b1; want_pulse(cyc + 3, cyc + 3, "R9 overcurrent pulse");
    idle(8); release_alarm();
    chk(alarm_n == 1'b0, "R9 alarm kept while fault present", alarm_n, 0);
    // R7: second fault during the first gives no pulse
    over_temp = 1'b1; idle(10);
    vcc_overcur = 1'b0; over_temp = 1'b0; idle(5); release_alarm();
    chk(alarm_n == 1'b1, "R9 released after fault gone", alarm_n, 1);
    over_temp = 1'b1; want_pulse(cyc + 3, cyc + 3, "R7 new onset pulses again");
    idle(8); over_temp = 1'b0; idle(5); release_alarm();

    // R4: higher threshold mode
    sel_low_thr = 1'b0; idle(5);
    vdd_below_lo = 1'b1; idle(300);
    chk(alarm_n == 1'b1, "R4 low comparator ignored", alarm_n, 1);
    vdd_below_lo = 1'b0; idle(5);
    // R5: short dips
    for (int k = 0; k < 4; k++) begin
      vdd_below_hi = 1'b1; idle((FILT - 10) * TP);
      vdd_below_hi = 1'b0; idle(8);
    end
    chk(alarm_n == 1'b1, "R5 short dips filtered", alarm_n, 1);
    vdd_below_hi = 1'b1;
    want_pulse(cyc + (FILT - 1) * TP, cyc + FILT * TP + TP + 4, "R4 filtered pulse window");
    idle(FILT * TP + 20);
    chk(alarm_n == 1'b0, "R4 alarm after sustained violation", alarm_n, 0);
    vdd_below_hi = 1'b0; idle(5); release_alarm();
    chk(alarm_n == 1'b1, "R8 release after filtered fault", alarm_n, 1);

    idle(10);
    chk(exp_q.size() == 0, "R7 all expected pulses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule